// File: doc/BRIEF.md
# Gated Scan Request Source

This block sits in front of an analog converter sequencer and decides which channel to convert next. Software programs a channel select mask and a mode register over a small synchronous register port. A load event moves the mask into a pending register. The load event can come from a software control bit, from an external trigger strobe, or from the end of a scan in autoscan mode. The block then requests the pending channels one at a time, lowest channel number first. Each pending bit is retired when the converter signals that its conversion is done.

Issuing is qualified by a gate with four modes: never, always, while the external gate level is high, or while it is low. A load either replaces the pending bits with the mask or ORs the mask into them. A single-cycle interrupt pulse can mark the end of a scan. With autoscan on, the scan restarts from the mask by itself.

Register map: address 0 holds the select mask in bits [N_CH-1:0]. Address 1 holds the mode register. Address 2 reads the pending bits and ignores writes. Address 3 reads zero. Mode register bits: [1:0] gate mode, 2 trigger enable, 3 interrupt enable, 4 autoscan enable, 5 merge load. Bits 8 and 9 are write-only action bits. Bit 12 is a read-only gate level.

Top module: `scan_req_src`

## Requirements
- R1: Gate mode bits [1:0] of the mode register select issuing. 0 never issues. 1 issues whenever bits are pending. 2 issues only while gate_i is 1. 3 issues only while gate_i is 0.
- R2: With mode bit 5 at 0, a load event replaces the pending register with the select mask.
- R3: With mode bit 5 at 1, a load event sets pending to the OR of the current pending bits and the select mask.
- R4: Writing mode bit 8 as 1 clears every pending bit. Writing it as 0 leaves pending unchanged.
- R5: Writing mode bit 9 as 1 causes exactly one load event. Writing it as 0 causes none.
- R6: A 1 on trig_i causes a load event only while mode bit 2 is 1. Otherwise it is ignored.
- R7: With mode bit 3 at 1, irq_o is high for exactly one cycle, in the cycle after done_i retires the last pending bit.
- R8: With mode bit 4 at 1, retiring the last pending bit triggers a load event one cycle later, so the scan repeats. With bit 4 at 0, the block stays idle after one scan.
- R9: Bit 12 of the mode register readback shows the current level of gate_i.
- R10: Only one request is outstanding at a time. It names the lowest pending channel and holds steady until done_i. Its pending bit is cleared on done_i.
- R11: When a clear and a load event fall in the same cycle, the clear is applied first, then the load.
- R12: Reads at address 0 return the mask and reads at address 2 return the pending bits. Action bits 8 and 9 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for read and write |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Combinational read data at addr_i |
| gate_i | input | 1 | External gate level |
| trig_i | input | 1 | External trigger strobe |
| done_i | input | 1 | Converter completed the outstanding request |
| req_valid_o | output | 1 | A conversion request is outstanding |
| req_ch_o | output | 3 | Channel of the outstanding request |
| irq_o | output | 1 | End-of-scan pulse |

## Verification
Issuing is driven with sparse masks such as channels 0, 3 and 5, which shows whether the order is lowest first and whether a bit is retired only on done. A single-channel mask is run under each gate mode with both gate levels, which separates the high-level mode from the low-level mode and the off mode from the always mode. Copy loads, merge loads and clear-with-load are applied to overlapping masks, so each ordering gives a different pending value. A two-channel autoscan run checks that the interrupt pulse and the reload land in distinct cycles after the last done.

// File: rtl/scan_req_pkg.sv
package scan_req_pkg;
  localparam int ADDR_W   = 2;
  localparam int DW       = 16;
  localparam logic [ADDR_W-1:0] A_SEL  = 2'd0;
  localparam logic [ADDR_W-1:0] A_MODE = 2'd1;
  localparam logic [ADDR_W-1:0] A_PND  = 2'd2;
  localparam int B_TRIG   = 2;
  localparam int B_IRQ    = 3;
  localparam int B_AUTO   = 4;
  localparam int B_MERGE  = 5;
  localparam int B_CLR    = 8;
  localparam int B_LDEV   = 9;
  localparam int B_GLVL   = 12;

  typedef enum logic [1:0] {
    GATE_OFF = 2'd0,
    GATE_ON  = 2'd1,
    GATE_HI  = 2'd2,
    GATE_LO  = 2'd3
  } gate_mode_e;

  typedef struct packed {
    logic       merge;
    logic       auto_en;
    logic       irq_en;
    logic       trig_en;
    gate_mode_e gate;
  } mode_t;
endpackage

// File: rtl/srs_regs.sv
module srs_regs
  import scan_req_pkg::*;
#(
  parameter int N_CH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic              gate_i,
  input  logic [N_CH-1:0]   pnd_i,
  output logic [N_CH-1:0]   sel_o,
  output mode_t             mode_o,
  output logic              clr_o,
  output logic              ldev_o,
  output logic [DW-1:0]     rd_data_o
);
  logic  [N_CH-1:0] sel_q;
  mode_t            mode_q;
  logic             mode_wr;

  assign mode_wr = wr_en_i && (addr_i == A_MODE);
  assign clr_o   = mode_wr && wr_data_i[B_CLR];
  assign ldev_o  = mode_wr && wr_data_i[B_LDEV];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      mode_q <= '0;
    end else if (wr_en_i) begin
      if (addr_i == A_SEL) sel_q <= wr_data_i[N_CH-1:0];
      if (mode_wr) begin
        mode_q.gate    <= gate_mode_e'(wr_data_i[1:0]);
        mode_q.trig_en <= wr_data_i[B_TRIG];
        mode_q.irq_en  <= wr_data_i[B_IRQ];
        mode_q.auto_en <= wr_data_i[B_AUTO];
        mode_q.merge   <= wr_data_i[B_MERGE];
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    unique case (addr_i)
      A_SEL:  rd_data_o[N_CH-1:0] = sel_q;
      A_MODE: begin
        rd_data_o[1:0]     = mode_q.gate;
        rd_data_o[B_TRIG]  = mode_q.trig_en;
        rd_data_o[B_IRQ]   = mode_q.irq_en;
        rd_data_o[B_AUTO]  = mode_q.auto_en;
        rd_data_o[B_MERGE] = mode_q.merge;
        rd_data_o[B_GLVL]  = gate_i;
      end
      A_PND:  rd_data_o[N_CH-1:0] = pnd_i;
      default: rd_data_o = '0;
    endcase
  end

  assign sel_o  = sel_q;
  assign mode_o = mode_q;

  // R5: action bit produces no state change in the select mask
  assert_ldev_keeps_sel_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ldev_o |=> sel_q == $past(sel_q));
endmodule

// File: rtl/srs_pending.sv
module srs_pending #(
  parameter int N_CH = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] sel_i,
  input  logic            merge_i,
  input  logic            clr_i,
  input  logic            load_i,
  input  logic [N_CH-1:0] done_mask_i,
  output logic [N_CH-1:0] pnd_o,
  output logic [N_CH-1:0] pnd_nxt_o
);
  logic [N_CH-1:0] pnd_q;

  // order: retire done bit, then clear, then load
  always_comb begin
    pnd_nxt_o = pnd_q & ~done_mask_i;
    if (clr_i)  pnd_nxt_o = '0;
    if (load_i) pnd_nxt_o = merge_i ? (pnd_nxt_o | sel_i) : sel_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pnd_q <= '0;
    else         pnd_q <= pnd_nxt_o;
  end

  assign pnd_o = pnd_q;

  assert_clear_empties_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !load_i |=> pnd_q == '0);
  assert_copy_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !merge_i |=> pnd_q == $past(sel_i));
  assert_merge_keeps_sel_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && merge_i |=> (pnd_q & $past(sel_i)) == $past(sel_i));
  assert_clear_then_load_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && load_i |=> pnd_q == $past(sel_i));
endmodule

// File: rtl/srs_issue.sv
module srs_issue
  import scan_req_pkg::*;
#(
  parameter int N_CH = 8,
  localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] pnd_i,
  input  logic [N_CH-1:0] pnd_nxt_i,
  input  gate_mode_e      gate_mode_i,
  input  logic            gate_i,
  input  logic            done_i,
  input  logic            irq_en_i,
  input  logic            auto_en_i,
  output logic            req_valid_o,
  output logic [CH_W-1:0] req_ch_o,
  output logic [N_CH-1:0] done_mask_o,
  output logic            irq_o,
  output logic            auto_load_o
);
  logic            busy_q, irq_q, auto_q;
  logic [CH_W-1:0] ch_q, low_idx;
  logic            gate_ok, issue_go, done_hit, last;

  always_comb begin
    unique case (gate_mode_i)
      GATE_OFF: gate_ok = 1'b0;
      GATE_ON:  gate_ok = 1'b1;
      GATE_HI:  gate_ok = gate_i;
      GATE_LO:  gate_ok = !gate_i;
      default:  gate_ok = 1'b0;
    endcase
  end

  // lowest set bit wins
  always_comb begin
    low_idx = '0;
    for (int i = N_CH - 1; i >= 0; i--)
      if (pnd_i[i]) low_idx = CH_W'(i);
  end

  assign issue_go    = !busy_q && gate_ok && (|pnd_i);
  assign done_hit    = busy_q && done_i;
  assign done_mask_o = done_hit ? (N_CH'(1) << ch_q) : '0;
  assign last        = done_hit && (pnd_nxt_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ch_q   <= '0;
      irq_q  <= 1'b0;
      auto_q <= 1'b0;
    end else begin
      if (issue_go) begin
        busy_q <= 1'b1;
        ch_q   <= low_idx;
      end else if (done_hit) begin
        busy_q <= 1'b0;
      end
      irq_q  <= irq_en_i && last;
      auto_q <= auto_en_i && last;
    end
  end

  assign req_valid_o = busy_q;
  assign req_ch_o    = ch_q;
  assign irq_o       = irq_q;
  assign auto_load_o = auto_q;

  assert_gate_off_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q && gate_mode_i == GATE_OFF |=> !busy_q);
  assert_req_held_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !done_i |=> busy_q && $stable(ch_q));
  assert_lowest_issued_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> ((($past(pnd_i) >> ch_q) & N_CH'(1)) == N_CH'(1)) &&
                      (($past(pnd_i) & ((N_CH'(1) << ch_q) - N_CH'(1))) == '0));
  assert_irq_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);
endmodule

// File: rtl/scan_req_src.sv
module scan_req_src
  import scan_req_pkg::*;
#(
  parameter int N_CH = 8,
  localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wr_data_i,
  output logic [DW-1:0]     rd_data_o,
  input  logic              gate_i,
  input  logic              trig_i,
  input  logic              done_i,
  output logic              req_valid_o,
  output logic [CH_W-1:0]   req_ch_o,
  output logic              irq_o
);
  logic [N_CH-1:0] sel, pnd, pnd_nxt, done_mask;
  mode_t           mode;
  logic            clr, ldev, auto_load, load;

  assign load = ldev || (trig_i && mode.trig_en) || auto_load;

  srs_regs #(.N_CH(N_CH)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wr_data_i, .gate_i,
    .pnd_i(pnd), .sel_o(sel), .mode_o(mode), .clr_o(clr), .ldev_o(ldev),
    .rd_data_o
  );

  srs_pending #(.N_CH(N_CH)) u_pnd (
    .clk_i, .rst_ni, .sel_i(sel), .merge_i(mode.merge), .clr_i(clr),
    .load_i(load), .done_mask_i(done_mask), .pnd_o(pnd), .pnd_nxt_o(pnd_nxt)
  );

  srs_issue #(.N_CH(N_CH)) u_iss (
    .clk_i, .rst_ni, .pnd_i(pnd), .pnd_nxt_i(pnd_nxt), .gate_mode_i(mode.gate),
    .gate_i, .done_i, .irq_en_i(mode.irq_en), .auto_en_i(mode.auto_en),
    .req_valid_o, .req_ch_o, .done_mask_o(done_mask), .irq_o,
    .auto_load_o(auto_load)
  );

  assert_trig_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i && !mode.trig_en && !ldev && !auto_load && !clr && !(|done_mask)
      |=> pnd == $past(pnd));
endmodule

// File: tb/tb_scan_req_src.sv
`timescale 1ns/1ps
module tb_scan_req_src;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [15:0] rd_data_o;
  logic        gate_i = 1'b0, trig_i = 1'b0, done_i = 1'b0;
  logic        req_valid_o, irq_o;
  logic [2:0]  req_ch_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  scan_req_src dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    wr_en_i = 1'b1; addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    addr_i = a; #0.5; d = rd_data_o;
  endtask

  task automatic ack();
    done_i = 1'b1;
    @(negedge clk_i);
    done_i = 1'b0;
  endtask

  task automatic trig_pulse();
    trig_i = 1'b1;
    @(negedge clk_i);
    trig_i = 1'b0;
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(2'd0, d); check("R12 sel reset", d, 0);
    rd(2'd1, d); check("R12 mode reset", d, 0);
    rd(2'd2, d); check("R12 pnd reset", d, 0);
    check("R10 reset valid", req_valid_o, 0);
    check("R7 reset irq", irq_o, 0);
  endtask

  task automatic t_priority();
    logic [15:0] d;
    wr(2'd0, 16'h0029);
    rd(2'd0, d); check("R12 sel readback", d, 16'h0029);
    wr(2'd1, 16'h0201);
    rd(2'd2, d); check("R2 copy load", d, 16'h0029);
    rd(2'd1, d); check("R12 action bits read 0", d, 16'h0001);
    cyc(1);
    check("R10 first valid", req_valid_o, 1);
    check("R10 lowest ch0", req_ch_o, 0);
    cyc(3);
    check("R10 held valid", req_valid_o, 1);
    check("R10 held ch", req_ch_o, 0);
    rd(2'd2, d); check("R10 bit kept until done", d, 16'h0029);
    ack();
    check("R10 idle after done", req_valid_o, 0);
    rd(2'd2, d); check("R10 bit retired", d, 16'h0028);
    cyc(1); check("R10 next ch3", req_ch_o, 3);
    ack(); cyc(1); check("R10 next ch5", req_ch_o, 5);
    ack();
    check("R7 no irq when disabled", irq_o, 0);
    cyc(3);
    check("R8 single scan stays idle", req_valid_o, 0);
    rd(2'd2, d); check("R8 pnd empty", d, 0);
  endtask

  task automatic t_gate();
    logic [15:0] d;
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'h0004);
    wr(2'd1, 16'h0200);
    cyc(3);
    check("R1 mode0 no issue", req_valid_o, 0);
    rd(2'd2, d); check("R1 mode0 keeps pnd", d, 16'h0004);
    wr(2'd1, 16'h0002);
    cyc(2);
    check("R1 mode2 gate low blocks", req_valid_o, 0);
    rd(2'd1, d); check("R9 gate level 0", d[12], 0);
    gate_i = 1'b1;
    rd(2'd1, d); check("R9 gate level 1", d[12], 1);
    @(negedge clk_i);
    check("R1 mode2 gate high issues", req_valid_o, 1);
    check("R1 mode2 ch", req_ch_o, 2);
    ack();
    wr(2'd1, 16'h0203);
    cyc(2);
    check("R1 mode3 gate high blocks", req_valid_o, 0);
    gate_i = 1'b0;
    @(negedge clk_i);
    check("R1 mode3 gate low issues", req_valid_o, 1);
    ack();
    wr(2'd1, 16'h0000);
  endtask

  task automatic t_merge_clear();
    logic [15:0] d;
    wr(2'd0, 16'h0003);
    wr(2'd1, 16'h0200);
    wr(2'd0, 16'h0030);
    wr(2'd1, 16'h0020);
    rd(2'd2, d); check("R5 no load without bit", d, 16'h0003);
    wr(2'd1, 16'h0220);
    rd(2'd2, d); check("R3 merge load", d, 16'h0033);
    wr(2'd1, 16'h0020);
    rd(2'd2, d); check("R4 zero clear bit no effect", d, 16'h0033);
    wr(2'd1, 16'h0120);
    rd(2'd2, d); check("R4 clear", d, 0);
    wr(2'd1, 16'h0220);
    rd(2'd2, d); check("R3 merge into empty", d, 16'h0030);
    wr(2'd0, 16'h000C);
    wr(2'd1, 16'h0320);
    rd(2'd2, d); check("R11 clear before load", d, 16'h000C);
    wr(2'd1, 16'h0100);
  endtask

  task automatic t_trigger();
    logic [15:0] d;
    wr(2'd0, 16'h0081);
    trig_pulse();
    rd(2'd2, d); check("R6 trigger ignored", d, 0);
    wr(2'd1, 16'h0004);
    trig_pulse();
    rd(2'd2, d); check("R6 trigger loads", d, 16'h0081);
    wr(2'd1, 16'h0100);
  endtask

  task automatic t_autoscan();
    logic [15:0] d;
    wr(2'd0, 16'h0006);
    wr(2'd1, 16'h0019);
    wr(2'd1, 16'h0219);
    cyc(1); check("R10 auto first ch1", req_ch_o, 1);
    ack();
    check("R7 no irq mid scan", irq_o, 0);
    cyc(1); check("R10 auto ch2", req_ch_o, 2);
    ack();
    check("R7 irq after last", irq_o, 1);
    rd(2'd2, d); check("R8 pnd empty before reload", d, 0);
    cyc(1);
    check("R7 irq one cycle", irq_o, 0);
    rd(2'd2, d); check("R8 auto reload", d, 16'h0006);
    check("R8 no issue on reload cycle", req_valid_o, 0);
    cyc(1);
    check("R8 rescan valid", req_valid_o, 1);
    check("R8 rescan ch1", req_ch_o, 1);
    wr(2'd1, 16'h0100);
    ack();
    cyc(3);
    check("R8 idle after autoscan off", req_valid_o, 0);
    check("R7 no irq after disable", irq_o, 0);
  endtask

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    t_reset();
    t_priority();
    t_gate();
    t_merge_clear();
    t_trigger();
    t_autoscan();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule